// File: doc/BRIEF.md
# Four-Phase Instruction Step Sequencer

This block is a synchronous test controller that paces a self-timed processor core through a test program. It does not give the core a clock. It releases the core one instruction at a time over a return-to-zero request/acknowledge pair. After a board reset, it first holds the core in clear for a long, fixed interval, so that all of the core's internal storage settles to a known state. Only after that interval does it begin stepping the core.

Each step follows the same order. Request rises and stays high until the core answers with acknowledge. Request then falls, and the step is complete once acknowledge has also returned low. After one idle cycle, the next request rises. The acknowledge pin comes from a clockless domain, so it is resynchronised before the sequencing logic uses it. A step counter advances each time a full handshake completes, which lets an observer follow progress.

The block also shows one observed data word from the core on a bank of LEDs that light when driven low. To do this it registers the bitwise complement of the word. All ports are plain control and status pins. There is no streaming data path, so there is no valid/ready back-pressure at the edge.

Top module: `core_step_sequencer`

## Requirements
- R1: `core_clr` is high while `brd_rst_n` is low. After reset is released, it stays high for exactly `CLR_CYCLES` rising clock edges and falls on the `CLR_CYCLES`-th edge. The default of 1,000,000 cycles is 20 ms at 50 MHz.
- R2: Asserting `brd_rst_n` low again while the clear pulse is running reloads the count. After the latest release, the pulse again lasts the full `CLR_CYCLES` edges.
- R3: `step_ack` passes through a two-flop synchroniser. When `step_ack` rises while `step_req` is high, `step_req` falls on the third rising edge after the change and not earlier.
- R4: The first `step_req` rises on the edge after `core_clr` falls (edge `CLR_CYCLES`+1 after release). `step_req` is never high while `core_clr` is high.
- R5: Once `step_req` is high, it stays high for as long as the synchronised acknowledge is low, however long the core takes.
- R6: After `step_req` falls, it stays low while `step_ack` is high. When `step_ack` falls, the next `step_req` rises on the fourth rising edge after the change. This leaves one idle cycle after the handshake completes.
- R7: `step_count` is 0 after reset. It increases by exactly one on the third rising edge after `step_ack` falls, which is when the handshake completes. It wraps modulo 2^`CNT_W`.
- R8: Pulling `brd_rst_n` low in the middle of a handshake drops `step_req` at once, without waiting for a clock. It also clears `step_count` to 0 and raises `core_clr`.
- R9: `led_n` equals the bitwise complement of `obs_word` sampled at the previous rising edge, which is a one-cycle latency. It is all ones (LEDs dark) while reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| brd_rst_n | input | 1 | Board reset, active low, asynchronous assert |
| core_clr | output | 1 | Clear pulse to the core, active high |
| step_req | output | 1 | Four-phase request to the core |
| step_ack | input | 1 | Four-phase acknowledge from the core (asynchronous) |
| obs_word | input | OBS_W | Observed register word from the core |
| led_n | output | OBS_W | Complemented observation word for active-low LEDs |
| step_count | output | CNT_W | Number of completed handshakes, wrapping |

## Verification
The embedded assertions cover the properties that hold on every cycle:
- a finished clear pulse never restarts without a reset;
- request never coexists with clear;
- request cannot rise while the synchronised acknowledge is high;
- request cannot fall while that acknowledge is low;
- the step count moves by at most one per edge;
- the LED bank always mirrors the complemented word from the edge before.

The exact latencies can only be shown by the bench's scenarios. These are the three- and four-edge delays through the synchroniser, the exact clear length, and its reload on a repeated reset. The bench sweeps every combination of short acknowledge delays, checks the counter wrap, applies a reset in mid-handshake, and runs every possible observation word.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    RESET_HOLD   = 2'd0,
    REQ_HIGH     = 2'd1,
    WAIT_ACK_LOW = 2'd2,
    IDLE_GAP     = 2'd3
  } hs_state_t;
endpackage

// File: rtl/csq_clr_stretch.sv
module csq_clr_stretch #(
  parameter int CLR_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic clr_o,
  output logic done_o
);
  localparam int CW = $clog2(CLR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CLR_CYCLES);

  logic [CW-1:0] remain;

  // reset holds the load value, so a repeated reset reloads the pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= LOAD;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign clr_o  = (remain != '0);
  assign done_o = ~clr_o;

  // R1
  clr_never_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  // R1
  clr_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/csq_ack_sync.sv
module csq_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain[0]) |=> sync_o);
endmodule

// File: rtl/csq_hs_fsm.sv
module csq_hs_fsm
  import csq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_done,
  input  logic             ack_s,
  output logic             req_o,
  output logic [CNT_W-1:0] count_o
);
  hs_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      RESET_HOLD:   if (clr_done && !ack_s) state_nx = REQ_HIGH;
      REQ_HIGH:     if (ack_s)              state_nx = WAIT_ACK_LOW;
      WAIT_ACK_LOW: if (!ack_s)             state_nx = IDLE_GAP;
      IDLE_GAP:                             state_nx = REQ_HIGH;
      default:                              state_nx = RESET_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RESET_HOLD;
      count_o <= '0;
    end else begin
      state <= state_nx;
      if (state == WAIT_ACK_LOW && !ack_s) count_o <= count_o + 1'b1;
    end
  end

  // asynchronous reset clears state, so request drops without a clock
  assign req_o = (state == REQ_HIGH);

  // R4
  no_req_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_done |-> !req_o);
  // R5
  req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_s) |=> req_o);
  // R6
  req_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_s));
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1) && !req_o);
endmodule

// File: rtl/csq_led_out.sv
module csq_led_out #(
  parameter int OBS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OBS_W-1:0] obs_i,
  output logic [OBS_W-1:0] led_n_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_n_o <= '1;
    else        led_n_o <= ~obs_i;
  end

  // R9
  led_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (led_n_o ^ $past(obs_i)) == '1);
endmodule

// File: rtl/core_step_sequencer.sv
module core_step_sequencer #(
  parameter int CLR_CYCLES = 1000000,
  parameter int OBS_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             brd_rst_n,
  output logic             core_clr,
  output logic             step_req,
  input  logic             step_ack,
  input  logic [OBS_W-1:0] obs_word,
  output logic [OBS_W-1:0] led_n,
  output logic [CNT_W-1:0] step_count
);
  logic clr_done;
  logic ack_s;

  csq_clr_stretch #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
    .clk(clk), .rst_n(brd_rst_n), .clr_o(core_clr), .done_o(clr_done)
  );

  csq_ack_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(brd_rst_n), .async_i(step_ack), .sync_o(ack_s)
  );

  csq_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(brd_rst_n), .clr_done(clr_done), .ack_s(ack_s),
    .req_o(step_req), .count_o(step_count)
  );

  csq_led_out #(.OBS_W(OBS_W)) u_led (
    .clk(clk), .rst_n(brd_rst_n), .obs_i(obs_word), .led_n_o(led_n)
  );
endmodule

// File: tb/core_step_sequencer_bench.sv
module core_step_sequencer_bench;
  localparam int CLR   = 12;
  localparam int OW    = 8;
  localparam int CW    = 4;

  logic          clk = 1'b0;
  logic          brd_rst_n = 1'b0;
  logic          step_ack = 1'b0;
  logic [OW-1:0] obs_word = '0;
  logic          core_clr, step_req;
  logic [OW-1:0] led_n;
  logic [CW-1:0] step_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  core_step_sequencer #(.CLR_CYCLES(CLR), .OBS_W(OW), .CNT_W(CW)) u_core_step_sequencer (
    .clk(clk), .brd_rst_n(brd_rst_n), .core_clr(core_clr), .step_req(step_req),
    .step_ack(step_ack), .obs_word(obs_word), .led_n(led_n), .step_count(step_count)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // starts at a negedge with reset low; ends at the negedge where req first rises
  task automatic release_and_clear();
    brd_rst_n = 1'b1;
    edges(CLR - 1);
    chk(core_clr == 1'b1, "R1 clr high before end", core_clr, 1);
    chk(step_req == 1'b0, "R4 req low during clr", step_req, 0);
    edges(1);
    chk(core_clr == 1'b0, "R1 clr falls on last edge", core_clr, 0);
    chk(step_req == 1'b0, "R4 req waits one edge", step_req, 0);
    edges(1);
    chk(step_req == 1'b1, "R4 first req", step_req, 1);
  endtask

  // one handshake; called at a negedge with req high
  task automatic one_step(input int rise_d, input int fall_d);
    for (int i = 0; i < rise_d; i++) begin
      edges(1);
      chk(step_req == 1'b1, "R5 req held awaiting ack", step_req, 1);
    end
    step_ack = 1'b1;
    edges(2);
    chk(step_req == 1'b1, "R3 req still high after two edges", step_req, 1);
    edges(1);
    chk(step_req == 1'b0, "R3 req falls on third edge", step_req, 0);
    for (int i = 0; i < fall_d; i++) begin
      edges(1);
      chk(step_req == 1'b0, "R6 req low while ack high", step_req, 0);
    end
    step_ack = 1'b0;
    edges(2);
    chk(int'(step_count) == exp_cnt, "R7 count before completion", step_count, exp_cnt);
    edges(1);
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk(int'(step_count) == exp_cnt, "R7 count after completion", step_count, exp_cnt);
    chk(step_req == 1'b0, "R6 idle gap cycle", step_req, 0);
    edges(1);
    chk(step_req == 1'b1, "R6 next req on fourth edge", step_req, 1);
  endtask

  initial begin
    edges(2);
    chk(core_clr == 1'b1, "R1 clr in reset", core_clr, 1);
    chk(step_req == 1'b0, "R8 req low in reset", step_req, 0);
    chk(step_count == '0, "R7 count zero in reset", step_count, 0);
    chk(led_n == '1, "R9 leds dark in reset", led_n, 255);

    // R2: reset again mid-pulse, then a full pulse must follow
    brd_rst_n = 1'b1;
    edges(CLR / 2);
    chk(core_clr == 1'b1, "R2 clr mid pulse", core_clr, 1);
    brd_rst_n = 1'b0;
    edges(1);
    release_and_clear();

    // sweep of acknowledge delays, 16 steps wraps the 4-bit count
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 4; f++)
        one_step(r, f);
    chk(step_count == '0, "R7 count wrapped", step_count, 0);
    one_step(1, 1);

    // R8: reset during a handshake with req high
    brd_rst_n = 1'b0;
    #1;
    chk(step_req == 1'b0, "R8 req drops at once", step_req, 0);
    chk(core_clr == 1'b1, "R8 clr raised", core_clr, 1);
    chk(step_count == '0, "R8 count cleared", step_count, 0);
    exp_cnt = 0;
    @(negedge clk);
    release_and_clear();
    one_step(2, 0);

    // R9: every observation word
    for (int v = 0; v < (1 << OW); v++) begin
      logic [OW-1:0] prev;
      prev = obs_word;
      obs_word = OW'(v);
      #1;
      chk(led_n == ~prev, "R9 led holds until edge", led_n, ~prev);
      edges(1);
      chk(led_n == ~OW'(v), "R9 led complement", led_n, ~OW'(v));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule